// File: doc/BRIEF.md
# Crossbar Configuration Write Port (two-wire serial target)

This block is the configuration front end of an eight-input, six-output video routing crossbar. It listens on a two-wire serial bus in Standard Mode (up to 100 kHz SCL) as a write-only target. SCL and SDA are oversampled on the system clock. The block detects START and STOP conditions and accepts an address byte whose top two bits come from two strap pins. It then takes a register-pointer byte and one or more data bytes. The block never returns data. Its only drive onto the bus is the acknowledge, pulled low through an open-drain style output.

Five internal bytes hold the configuration, and the block presents them decoded as parallel outputs. Each output has a 4-bit input-select code and an enable. Each input has a clamp-or-bias select. Each output has a gain select. The analog switch, the clamp circuits and the amplifiers lie outside this block and are driven by these outputs.

Top module: `xbar_i2c_cfg`

## Requirements
- R1: After reset, every input select is 0000, every output enable is low, every clamp select and gain select is 0, and `sdaPullLow` is low.
- R2: An address byte equal to `{strapAddr[1], strapAddr[0], 6'b000110}` (R/W bit 0 in bit 0), i.e. 0x06, 0x46, 0x86 or 0xC6, is acknowledged.
- R3: An address byte that does not match the strap-derived value is not acknowledged, and the bytes that follow it in that transaction neither get an acknowledge nor change any configuration.
- R4: A matching address with the R/W bit set (0x07 for straps 00) is not acknowledged, and the block ignores the bus until the next START.
- R5: For the address, pointer and every data byte it accepts, the block holds SDA low through the high phase of the ninth clock and releases it after that clock falls.
- R6: Register 0, register 1 and register 2 hold selects for outputs 1/2, 3/4 and 5/6. The odd-numbered output takes bits 3:0 and the even-numbered output takes bits 7:4. Output k's select appears on `inSel[4k-1:4k-4]`.
- R7: Select code 0000 drives the output's enable bit low. Codes 0001 to 1000 pick inputs 1 to 8 with the enable high. Several outputs may carry the same code.
- R8: Register 3 bit i drives `clampSel[i]` for input i+1, where 1 means clamp and 0 means bias.
- R9: Register 4 bits 5:0 drive `gainUnity[5:0]` for outputs 6 to 1, where 1 means 0 dB and 0 means 6 dB. Bits 7:6 are discarded.
- R10: A data byte written to any pointer above 4 is acknowledged and changes no output.
- R11: Each data byte after the first in a transaction is acknowledged and written to the next pointer value.
- R12: A repeated START (no STOP in between) restarts address matching, and the next pointer and data bytes are handled as in a fresh transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| strapAddr | input | 2 | Strap pins that form address bits 7:6 |
| sdaPullLow | output | 1 | 1 pulls SDA low (acknowledge) |
| inSel | output | 24 | Per-output 4-bit input select, output 1 in bits 3:0 |
| outEn | output | 6 | Per-output driver enable, low when select is 0000 |
| clampSel | output | 8 | Per-input clamp (1) or bias (0) |
| gainUnity | output | 6 | Per-output gain, 1 = 0 dB, 0 = 6 dB |

## Verification
The bench runs all four strap settings and checks that an address formed for a different strap is refused. A design that ignored the straps would answer several addresses on the same bus. The bench sends a correct address with the read bit set and follows it with data bytes. A design that compared only seven bits would acknowledge those bytes and corrupt the configuration. Auto-increment is driven across the last defined register into undefined pointers, which exposes a pointer that wraps or a write that lands in the wrong register. A repeated START inside a transaction catches a state machine that waits for a STOP before it matches addresses again. Writes of code 0000 next to shared codes show whether the enables follow the nibble packing.

// File: rtl/xbar_i2c_pkg.sv
package xbar_i2c_pkg;

  // strobes from the bus control to the register datapath
  typedef struct packed {
    logic shiftBit;   // take sdaBit into the receive shifter
    logic loadPtr;    // received byte becomes the register pointer
    logic writeReg;   // received byte is written at the pointer, pointer advances
  } ctrlStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_DATA,
    ST_SKIP
  } busState_t;

endpackage

// File: rtl/xbar_i2c_ctrl.sv
module xbar_i2c_ctrl
  import xbar_i2c_pkg::*;
#(
  parameter logic [7:0] BASE_BYTE = 8'h06,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [1:0]  strapAddr,
  input  logic [7:0]  rxByte,
  output ctrlStrobe_t strobe,
  output logic        sdaBit,
  output logic        sdaPullLow
);

  localparam int BIT_W = 4;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(8);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic startDet, stopDet, sclRise, sclFall;
  busState_t state;
  logic [BIT_W-1:0] bitCnt;
  logic ackPhase;
  logic active, byteDone, addrOk, accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaS     = sdaSync[SYNC_STAGES-1];
  assign startDet = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopDet  = sclS && sclPrev && !sdaPrev && sdaS;
  assign sclRise  = sclS && !sclPrev;
  assign sclFall  = !sclS && sclPrev;
  assign sdaBit   = sdaS;

  assign active   = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_DATA);
  assign byteDone = active && sclFall && !ackPhase && (bitCnt == LAST_BIT);
  assign addrOk   = (rxByte == {strapAddr, BASE_BYTE[5:0]});
  assign accept   = (state == ST_ADDR) ? addrOk : 1'b1;

  always_comb begin
    strobe          = '0;
    strobe.shiftBit = active && sclRise && !ackPhase && (bitCnt < LAST_BIT);
    strobe.loadPtr  = byteDone && (state == ST_PTR);
    strobe.writeReg = byteDone && (state == ST_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      ackPhase   <= 1'b0;
      sdaPullLow <= 1'b0;
    end else if (startDet) begin
      state      <= ST_ADDR;
      bitCnt     <= '0;
      ackPhase   <= 1'b0;
      sdaPullLow <= 1'b0;
    end else if (stopDet) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      ackPhase   <= 1'b0;
      sdaPullLow <= 1'b0;
    end else if (active) begin
      if (strobe.shiftBit) bitCnt <= bitCnt + BIT_W'(1);
      if (sclFall) begin
        if (ackPhase) begin
          ackPhase   <= 1'b0;
          sdaPullLow <= 1'b0;
          bitCnt     <= '0;
          state      <= (state == ST_ADDR) ? ST_PTR : ST_DATA;
        end else if (byteDone) begin
          if (accept) begin
            ackPhase   <= 1'b1;
            sdaPullLow <= 1'b1;
          end else begin
            state <= ST_SKIP;
          end
        end
      end
    end
  end

endmodule

// File: rtl/xbar_i2c_regs.sv
module xbar_i2c_regs
  import xbar_i2c_pkg::*;
#(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  input  logic                    sdaBit,
  output logic [7:0]              rxByte,
  output logic [NUM_OUT*4-1:0]    inSel,
  output logic [NUM_OUT-1:0]      outEn,
  output logic [NUM_IN-1:0]       clampSel,
  output logic [NUM_OUT-1:0]      gainUnity
);

  localparam int SEL_W        = 4;
  localparam int NUM_SEL_REGS = (NUM_OUT + 1) / 2;
  localparam int CLAMP_IDX    = NUM_SEL_REGS;
  localparam int GAIN_IDX     = NUM_SEL_REGS + 1;

  logic [7:0]          shiftReg;
  logic [7:0]          ptr;
  logic [7:0]          selRegs [NUM_SEL_REGS];
  logic [NUM_IN-1:0]   clampReg;
  logic [NUM_OUT-1:0]  gainReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      ptr      <= '0;
      selRegs  <= '{default: '0};
      clampReg <= '0;
      gainReg  <= '0;
    end else begin
      if (strobe.shiftBit) shiftReg <= {shiftReg[6:0], sdaBit};
      if (strobe.loadPtr)  ptr <= shiftReg;
      if (strobe.writeReg) begin
        ptr <= ptr + 8'd1;
        for (int r = 0; r < NUM_SEL_REGS; r++) begin
          if (ptr == 8'(r)) selRegs[r] <= shiftReg;
        end
        if (ptr == 8'(CLAMP_IDX)) clampReg <= shiftReg[NUM_IN-1:0];
        if (ptr == 8'(GAIN_IDX))  gainReg  <= shiftReg[NUM_OUT-1:0];
      end
    end
  end

  assign rxByte = shiftReg;

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [SEL_W-1:0] selCode;
    assign selCode                 = selRegs[o/2][(o%2)*SEL_W +: SEL_W];
    assign inSel[o*SEL_W +: SEL_W] = selCode;
    assign outEn[o]                = (selCode != '0);
  end

  assign clampSel  = clampReg;
  assign gainUnity = gainReg;

endmodule

// File: rtl/xbar_i2c_cfg.sv
module xbar_i2c_cfg
  import xbar_i2c_pkg::*;
#(
  parameter int         NUM_IN    = 8,
  parameter int         NUM_OUT   = 6,
  parameter logic [7:0] BASE_BYTE = 8'h06
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  logic [1:0]            strapAddr,
  output logic                  sdaPullLow,
  output logic [NUM_OUT*4-1:0]  inSel,
  output logic [NUM_OUT-1:0]    outEn,
  output logic [NUM_IN-1:0]     clampSel,
  output logic [NUM_OUT-1:0]    gainUnity
);

  ctrlStrobe_t strobe;
  logic        sdaBit;
  logic [7:0]  rxByte;

  xbar_i2c_ctrl #(.BASE_BYTE(BASE_BYTE), .SYNC_STAGES(2)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .strapAddr  (strapAddr),
    .rxByte     (rxByte),
    .strobe     (strobe),
    .sdaBit     (sdaBit),
    .sdaPullLow (sdaPullLow)
  );

  xbar_i2c_regs #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sdaBit    (sdaBit),
    .rxByte    (rxByte),
    .inSel     (inSel),
    .outEn     (outEn),
    .clampSel  (clampSel),
    .gainUnity (gainUnity)
  );

endmodule

// File: rtl/xbar_i2c_cfg_chk.sv
module xbar_i2c_cfg_chk #(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 6
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            sclIn,
  input logic                            sdaPullLow,
  input logic [NUM_OUT*6+NUM_IN-1:0]     cfgBus
);

  // configuration changes only in the cycle the acknowledge starts
  AST_CFG_ON_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (cfgBus != $past(cfgBus)) |-> $rose(sdaPullLow)); // R5

  AST_ACK_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclIn); // R5

  AST_ACK_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullLow) |-> !sclIn); // R5

  AST_ACK_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ($past(sdaPullLow) && sclIn && $past(sclIn)) |-> sdaPullLow); // R5

endmodule

bind xbar_i2c_cfg xbar_i2c_cfg_chk #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sclIn      (sclIn),
  .sdaPullLow (sdaPullLow),
  .cfgBus     ({inSel, outEn, clampSel, gainUnity})
);

// File: tb/xbar_i2c_cfg_bench.sv
module xbar_i2c_cfg_bench;

  localparam int Q = 20;  // clocks per quarter SCL period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [1:0] strapAddr = 2'b00;
  logic sdaPullLow;
  logic [23:0] inSel;
  logic [5:0]  outEn;
  logic [7:0]  clampSel;
  logic [5:0]  gainUnity;
  logic sdaLine;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] mdl [5];

  always #2.5 clk = ~clk;
  assign sdaLine = sdaM & ~sdaPullLow;

  xbar_i2c_cfg u_xbar_i2c_cfg (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .strapAddr(strapAddr),
    .sdaPullLow(sdaPullLow), .inSel(inSel), .outEn(outEn),
    .clampSel(clampSel), .gainUnity(gainUnity)
  );

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] addrOf(input logic [1:0] s, input logic rd);
    return {s, 5'b00011, rd};
  endfunction

  task automatic compareAll(input string req);
    logic [23:0] expSel;
    logic [5:0]  expEn;
    for (int o = 0; o < 6; o++) begin
      logic [3:0] nib;
      nib = (o % 2 == 0) ? mdl[o/2][3:0] : mdl[o/2][7:4];
      expSel[o*4 +: 4] = nib;
      expEn[o] = (nib != 4'd0);
    end
    chk({req, " inSel"}, 32'(inSel), 32'(expSel));
    chk({req, " outEn"}, 32'(outEn), 32'(expEn));
    chk({req, " clampSel"}, 32'(clampSel), 32'(mdl[3]));
    chk({req, " gainUnity"}, 32'(gainUnity), 32'(mdl[4][5:0]));
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic putByte(input logic [7:0] b, input logic expAck, input string req);
    logic acked;
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ();
      sclM = 1'b1; waitQ(); waitQ();
      sclM = 1'b0; waitQ();
    end
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    acked = (sdaLine == 1'b0);
    waitQ();
    sclM = 1'b0; waitQ();
    chk({req, " ack"}, 32'(acked), 32'(expAck));
  endtask

  task automatic writeOne(input logic [7:0] p, input logic [7:0] d, input string req);
    busStart();
    putByte(addrOf(strapAddr, 1'b0), 1'b1, req);
    putByte(p, 1'b1, req);
    putByte(d, 1'b1, req);
    busStop();
    if (p < 8'd5) mdl[p[2:0]] = d;
  endtask

  task automatic testReset();
    for (int r = 0; r < 5; r++) mdl[r] = 8'h00;
    compareAll("R1 reset");
    chk("R1 sda released", 32'(sdaPullLow), 32'd0);
  endtask

  task automatic testBasicRoute();
    writeOne(8'h00, 8'h21, "R2 R5");
    compareAll("R6 out1=in1 out2=in2");
    writeOne(8'h01, 8'h08, "R5");
    compareAll("R7 out3=in8 out4 off");
  endtask

  task automatic testStraps();
    for (int s = 0; s < 4; s++) begin
      strapAddr = 2'(s);
      writeOne(8'h02, 8'(8'h10 * (s + 1) + 2), "R2 strap");
      compareAll("R2 strap write");
      busStart();
      putByte(addrOf(2'(s + 1), 1'b0), 1'b0, "R3 other strap");
      busStop();
    end
    strapAddr = 2'b00;
  endtask

  task automatic testMismatch();
    busStart();
    putByte(8'h08, 1'b0, "R3 bad address");
    putByte(8'h00, 1'b0, "R3 pointer ignored");
    putByte(8'hFF, 1'b0, "R3 data ignored");
    busStop();
    compareAll("R3 no change");
  endtask

  task automatic testReadBit();
    busStart();
    putByte(addrOf(strapAddr, 1'b1), 1'b0, "R4 read bit");
    putByte(8'h00, 1'b0, "R4 pointer ignored");
    putByte(8'h77, 1'b0, "R4 data ignored");
    busStop();
    compareAll("R4 no change");
  endtask

  task automatic testBurst();
    busStart();
    putByte(addrOf(strapAddr, 1'b0), 1'b1, "R11 addr");
    putByte(8'h00, 1'b1, "R11 ptr");
    putByte(8'h11, 1'b1, "R11 d0"); mdl[0] = 8'h11;
    putByte(8'h33, 1'b1, "R11 d1"); mdl[1] = 8'h33;
    putByte(8'h55, 1'b1, "R11 d2"); mdl[2] = 8'h55;
    putByte(8'hA5, 1'b1, "R11 d3"); mdl[3] = 8'hA5;
    putByte(8'hFF, 1'b1, "R11 d4"); mdl[4] = 8'hFF;
    busStop();
    compareAll("R11 R7 R8 R9 burst");
    chk("R7 shared input out1/out2", 32'(inSel[7:0]), 32'h11);
    chk("R9 upper bits dropped", 32'(gainUnity), 32'h3F);
    chk("R8 clamp input1", 32'(clampSel[0]), 32'd1);
  endtask

  task automatic testUndefined();
    busStart();
    putByte(addrOf(strapAddr, 1'b0), 1'b1, "R10 addr");
    putByte(8'h04, 1'b1, "R10 ptr");
    putByte(8'h2A, 1'b1, "R10 gain"); mdl[4] = 8'h2A;
    putByte(8'h3C, 1'b1, "R10 ptr5 acked");
    putByte(8'h00, 1'b1, "R10 ptr6 acked");
    busStop();
    compareAll("R10 after 5/6");
    writeOne(8'h80, 8'hFF, "R10 ptr80");
    compareAll("R10 ptr80 no effect");
  endtask

  task automatic testRepeatedStart();
    busStart();
    putByte(addrOf(strapAddr, 1'b0), 1'b1, "R12 first addr");
    putByte(8'h03, 1'b1, "R12 first ptr");
    busStart();
    putByte(addrOf(strapAddr, 1'b0), 1'b1, "R12 re-addr");
    putByte(8'h02, 1'b1, "R12 re-ptr");
    putByte(8'h80, 1'b1, "R12 data"); mdl[2] = 8'h80;
    busStop();
    compareAll("R12 routed after repeated start");
    chk("R7 out5 off", 32'(outEn[4]), 32'd0);
    busStart();
    putByte(addrOf(strapAddr, 1'b0), 1'b1, "R12 addr2");
    busStart();
    putByte(8'h20, 1'b0, "R12 bad after restart");
    putByte(8'h00, 1'b0, "R12 ignored");
    busStop();
    compareAll("R12 no change");
  endtask

  task automatic testOffAll();
    writeOne(8'h00, 8'h00, "R7 off");
    compareAll("R7 off");
    chk("R7 out1/out2 disabled", 32'(outEn[1:0]), 32'd0);
  endtask

  task automatic testMidReset();
    @(negedge clk) rstN = 1'b0;
    repeat (4) @(negedge clk);
    for (int r = 0; r < 5; r++) mdl[r] = 8'h00;
    compareAll("R1 reset again");
    rstN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(negedge clk);
    rstN = 1'b1;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    testReset();
    wait (rstN);
    repeat (5) @(negedge clk);
    testBasicRoute();
    testStraps();
    testMismatch();
    testReadBit();
    testBurst();
    testUndefined();
    testRepeatedStart();
    testOffAll();
    testMidReset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule